// File: doc/BRIEF.md
# Run-Time Configurable Sum-of-Products Array

This block evaluates a set of logic functions written as sums of products. Both planes are held in registers. The AND plane gives a literal code for every input of every product term. The OR plane gives a connection mask for every term. Software or a controlling state machine loads the array one term row at a time through a synchronous write port. The outputs are computed combinationally from the logic inputs and the stored rows, with no register in that path.

A mode input selects how terms reach the OR gates. In shared mode, any term can feed any output, and one term can feed several outputs at once. In grouped mode, each output has its own fixed block of four terms, and no other term can reach it. Reset models a blank array. Every term is left with all literals absent and is connected to every output, so each output reads 1 until rows are written.

Top module: `cfg_pla`

## Requirements
- R1: The literal code of input i sits in bits [2i+1:2i] of a row's literal field. Code 00 means the input does not take part. Code 01 requires the input to be 0. Code 10 requires the input to be 1. A term is 1 only when every literal it uses is met.
- R2: Literal code 11 in any field forces that term to 0 for all input values.
- R3: A term whose fields are all 00 evaluates to 1. An output with no connected term evaluates to 0.
- R4: In shared mode (`grp_mode`=0), bit k of a row's mask ORs that term into output k. One term can drive several outputs.
- R5: In grouped mode (`grp_mode`=1), output k uses only terms 4k to 4k+3, each gated by mask bit k. Masks of all other terms have no effect on output k.
- R6: After reset, every literal field is 00 and every mask bit is 1, so every output reads 1 for every input pattern and in both modes.
- R7: When `cfg_we` is 1 at a rising clock edge, that edge loads the literal field and mask into row `cfg_row`, and the result shows after the edge. All other rows stay unchanged. When `cfg_we` is 0, no row changes.
- R8: `dout` follows `din` and `grp_mode` with no clock edge in between.
- R9: With din[2]=A, din[1]=B and din[0]=C, five shared terms program F0=A+B'C', F1=AC'+AB, F2=B'C'+AB and F3=B'C+A. These functions hold on dout[3:0] for all 8 input patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset to the blank array |
| grp_mode | input | 1 | 0 = shared terms, 1 = fixed group of four terms per output |
| cfg_we | input | 1 | Row write enable |
| cfg_row | input | $clog2(N_TERM) | Row being written |
| cfg_lits | input | 2*N_IN | Literal codes, two bits per input |
| cfg_mask | input | N_OUT | Output connection mask for the row |
| din | input | N_IN | Logic inputs |
| dout | output | N_OUT | Function outputs |

## Verification
The hardest case to reach from the ports is grouped mode isolation. An output must ignore a live, connected term outside its own group. After reset every term is live and connected to every output, so nothing can be isolated. The stimulus first kills every row with code 11 while leaving all mask bits set. It then revives one term in a single group. In that state shared mode and grouped mode must give different outputs. Random rows and mode changes then continue from there.

// File: rtl/cfg_pla.sv
module cfg_pla #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int AW    = $clog2(N_TERM),
  localparam int LW    = 2 * N_IN,
  localparam int GRP   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_mode,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_row,
  input  logic [LW-1:0]    cfg_lits,
  input  logic [N_OUT-1:0] cfg_mask,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout
);

  logic [N_TERM-1:0][LW-1:0]    lit_q;
  logic [N_TERM-1:0][N_OUT-1:0] mask_q;
  logic [N_TERM-1:0]            term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit_q  <= '0;
      mask_q <= '1;
    end else if (cfg_we) begin
      lit_q[cfg_row]  <= cfg_lits;
      mask_q[cfg_row] <= cfg_mask;
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_and
    logic [N_IN-1:0] lit_ok;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      wire [1:0] code = lit_q[t][2*i+1:2*i];
      assign lit_ok[i] = (code == 2'b00) |
                         (code == 2'b01 & ~din[i]) |
                         (code == 2'b10 &  din[i]);
    end
    assign term[t] = &lit_ok;
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_or
    logic [N_TERM-1:0] reach;
    for (genvar t = 0; t < N_TERM; t++) begin : g_reach
      if ((t / GRP) == k) begin : g_own
        assign reach[t] = mask_q[t][k];
      end else begin : g_other
        assign reach[t] = mask_q[t][k] & ~grp_mode;
      end
    end
    assign dout[k] = |(term & reach);
  end

endmodule

// File: rtl/cfg_pla_chk.sv
module cfg_pla_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  localparam int AW    = $clog2(N_TERM),
  localparam int LW    = 2 * N_IN
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_we,
  input logic [AW-1:0]                cfg_row,
  input logic [LW-1:0]                cfg_lits,
  input logic [N_OUT-1:0]             cfg_mask,
  input logic [N_TERM-1:0][LW-1:0]    lit_q,
  input logic [N_TERM-1:0][N_OUT-1:0] mask_q,
  input logic [N_TERM-1:0]            term,
  input logic [N_OUT-1:0]             dout
);

  function automatic logic has_kill(input logic [LW-1:0] l);
    logic r = 1'b0;
    for (int i = 0; i < N_IN; i++) r |= (l[2*i+:2] == 2'b11);
    return r;
  endfunction

  AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (lit_q[$past(cfg_row)] == $past(cfg_lits)) &&
               (mask_q[$past(cfg_row)] == $past(cfg_mask))); // R7

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(lit_q) && $stable(mask_q)); // R7

  for (genvar t = 0; t < N_TERM; t++) begin : g_t
    AST_FREE_TERM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (lit_q[t] == '0) |-> term[t]); // R3
    AST_KILLED_TERM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      has_kill(lit_q[t]) |-> !term[t]); // R2
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_k
    logic [N_TERM-1:0] col;
    for (genvar t = 0; t < N_TERM; t++) begin : g_c
      assign col[t] = mask_q[t][k];
    end
    AST_EMPTY_COLUMN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (col == '0) |-> !dout[k]); // R3
  end

endmodule

bind cfg_pla cfg_pla_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
  .cfg_lits(cfg_lits), .cfg_mask(cfg_mask), .lit_q(lit_q), .mask_q(mask_q),
  .term(term), .dout(dout)
);

// File: tb/cfg_pla_test.sv
module cfg_pla_test;
  localparam int N = 3, P = 16, M = 4, AW = $clog2(P), LW = 2 * N;

  logic clk = 1'b0, rst_n = 1'b0, grp_mode = 1'b0, cfg_we = 1'b0;
  logic [AW-1:0] cfg_row = '0;
  logic [LW-1:0] cfg_lits = '0;
  logic [M-1:0]  cfg_mask = '0;
  logic [N-1:0]  din = '0;
  logic [M-1:0]  dout;

  logic [LW-1:0] ml [P];
  logic [M-1:0]  mm [P];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_pla #(.N_IN(N), .N_TERM(P), .N_OUT(M)) uut (.*);

  function automatic logic [M-1:0] model(input logic [N-1:0] x, input logic g);
    logic [M-1:0] r = '0;
    for (int t = 0; t < P; t++) begin
      logic tv = 1'b1;
      for (int i = 0; i < N; i++) begin
        case (ml[t][2*i+:2])
          2'b01: tv &= ~x[i];
          2'b10: tv &=  x[i];
          2'b11: tv = 1'b0;
          default: ;
        endcase
      end
      for (int k = 0; k < M; k++)
        if (!g || (t / 4) == k) r[k] |= tv & mm[t][k];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [M-1:0] exp);
    n_chk++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: din=%b mode=%b dout=%b expected=%b", tag, din, grp_mode, dout, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] x, input logic g);
    @(negedge clk);
    din = x; grp_mode = g;
    #1;
  endtask

  task automatic wr(input int row, input logic [LW-1:0] l, input logic [M-1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = AW'(row); cfg_lits = l; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
    ml[row] = l; mm[row] = m;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic A, B, C;
    for (int t = 0; t < P; t++) begin ml[t] = '0; mm[t] = '1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      apply(N'(v), v[0]);
      check("R6 blank array", '1);
    end

    wr(0, 6'b10_00_00, 4'b1001);
    wr(1, 6'b00_01_01, 4'b0101);
    wr(2, 6'b10_00_01, 4'b0010);
    wr(3, 6'b10_10_00, 4'b0110);
    wr(4, 6'b00_01_10, 4'b1000);
    for (int r = 5; r < P; r++) wr(r, 6'b11_11_11, 4'b0000);
    for (int v = 0; v < 8; v++) begin
      apply(N'(v), 1'b0);
      A = din[2]; B = din[1]; C = din[0];
      check("R9 R1 R4 reference functions",
            {(~B & C) | A, (~B & ~C) | (A & B), (A & ~C) | (A & B), A | (~B & ~C)});
    end

    @(negedge clk);
    din = 3'b000; #1; check("R8 no clock", model(3'b000, 1'b0));
    din = 3'b101; #1; check("R8 no clock", model(3'b101, 1'b0));
    grp_mode = 1'b1; #1; check("R8 mode change", model(3'b101, 1'b1));

    wr(0, 6'b10_00_11, 4'b1001);
    for (int v = 4; v < 8; v++) begin
      apply(N'(v), 1'b0);
      check("R2 kill code", model(din, 1'b0));
    end

    for (int r = 0; r < P; r++) wr(r, 6'b00_00_00, 4'b0000);
    apply(3'b110, 1'b0); check("R3 empty columns", 4'b0000);
    wr(3, 6'b00_00_00, 4'b1111);
    apply(3'b001, 1'b0); check("R3 free term", 4'b1111);

    for (int r = 0; r < P; r++) wr(r, 6'b11_11_11, 4'b1111);
    wr(9, 6'b00_00_00, 4'b1111);
    apply(3'b011, 1'b1); check("R5 group isolation", 4'b0100);
    apply(3'b011, 1'b0); check("R5 shared contrast", 4'b1111);
    wr(9, 6'b00_00_00, 4'b1011);
    apply(3'b011, 1'b1); check("R5 own mask bit", 4'b0000);

    @(negedge clk);
    cfg_row = AW'(9); cfg_lits = 6'b00_00_00; cfg_mask = 4'b1111;
    @(negedge clk);
    apply(3'b011, 1'b1); check("R7 write disabled", 4'b0000);

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 2 == 0) begin
        logic [LW-1:0] l;
        for (int i = 0; i < N; i++) begin
          logic [1:0] c = 2'($urandom % 4);
          if (c == 2'b11 && $urandom % 4 != 0) c = 2'b00;
          l[2*i+:2] = c;
        end
        wr(int'($urandom % P), l, M'($urandom));
      end
      apply(N'($urandom), 1'($urandom));
      check("R4 R5 R7 random", model(din, grp_mode));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule